// File: doc/BRIEF.md
# 1-Wire Bit-Level Bus Master

This block is the lowest layer of a 1-Wire host. It owns one open-drain line and turns a single request from the layer above into one correctly timed line event. Three events are available: the bus reset (with detection of a device's presence reply), a write slot carrying one bit, and a read slot returning one bit. The line is only ever pulled low. An external pull-up returns it high, so the block exposes a pull-low enable rather than a driven level.

The layer above selects an operation, supplies the bit to write, and pulses a start strobe while the block is idle. The block raises `busy_o` for the whole event. When the event ends it drops `busy_o` and pulses `done_o` for one clock. After a read slot the sampled bit appears on `rbit_o`. After a reset the presence result appears on `presence_o`. Both results hold until the next operation of the same kind. All durations are counted in microseconds, and a microsecond is `CLKS_PER_US` system clocks. The incoming line passes through a synchronizer before it is sampled. Byte assembly, device addressing and bus enumeration belong to the layer above.

Top module: `owire_bitmaster`

## Requirements
- R1: After the synchronous reset `rst`, `pull_low_o`, `busy_o`, `done_o`, `rbit_o` and `presence_o` are all 0. `pull_low_o` is never 1 while `busy_o` is 0.
- R2: A start with `op_i` = 2'b00 (bus reset) asserts `pull_low_o` for exactly 480 µs. The block then stays busy for 960 µs in total, counted from the clock edge that accepts the start.
- R3: During a bus reset, the synchronized line is sampled 70 µs after the pull-low ends. `presence_o` becomes 1 if the line was low and 0 if it was high. It changes only at the `done_o` of a bus reset and holds its value across other operations.
- R4: A start with `op_i` = 2'b01 (write) pulls low for 6 µs when `wbit_i` = 1 and for 60 µs when `wbit_i` = 0. The slot lasts 61 µs in total.
- R5: A start with `op_i` = 2'b10 (read) pulls low for 6 µs and samples the synchronized line 15 µs into the slot. The slot lasts 61 µs. `rbit_o` takes the sampled level and changes only at the `done_o` of a read.
- R6: At the end of every operation, `busy_o` falls and `done_o` is 1 on the same clock. `done_o` lasts exactly one clock and occurs once per accepted operation.
- R7: A start while `busy_o` is 1 is ignored and does not change the running operation's timing. A start with `op_i` = 2'b11 is ignored: `busy_o`, `pull_low_o` and `done_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| op_i | input | 2 | Operation: 00 bus reset, 01 write, 10 read, 11 none |
| wbit_i | input | 1 | Bit to send in a write slot |
| line_i | input | 1 | Level of the bus line (asynchronous) |
| pull_low_o | output | 1 | 1 enables the pull-down on the bus line |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock pulse at the end of an operation |
| rbit_o | output | 1 | Bit sampled by the last read slot |
| presence_o | output | 1 | Presence result of the last bus reset |

## Verification
The checker enforces the following on every cycle:
- a one-clock `done_o` that coincides with the fall of `busy_o`;
- the absence of pull-low while idle;
- busy starting only from a start strobe;
- ignored no-operation requests;
- `rbit_o` and `presence_o` changing only at a completion.

The exact microsecond lengths of the pull-low and the whole event for each operation need the bench's scenarios, and so do the sampled results. A behavioural device model in the bench answers resets with a presence pulse and holds the line low for read zeros. A start injected mid-slot shows that the running slot keeps its length.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } owire_op_e;

endpackage

// File: rtl/owire_us_tick.sv
// Microsecond prescaler; restart realigns the count to the accepting edge.
module owire_us_tick #(
  parameter int CLKS_PER_US = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);

  logic [PW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/owire_line_sync.sv
// Multi-flop synchronizer for the open-drain line; idles high.
module owire_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_async,
  output logic line_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= line_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b1;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign line_sync = chain[STAGES-1];
endmodule

// File: rtl/owire_slot_seq.sv
// Sequencer: one microsecond counter per event, compared against
// per-operation thresholds for release, sample and end.
module owire_slot_seq
  import owire_pkg::*;
#(
  parameter int RST_LOW_US   = 480,
  parameter int RST_TOTAL_US = 960,
  parameter int PRES_WAIT_US = 70,
  parameter int SLOT_US      = 61,
  parameter int SHORT_LOW_US = 6,
  parameter int LONG_LOW_US  = 60,
  parameter int READ_AT_US   = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       wbit_i,
  input  logic       line_s,
  output logic       accept,
  output logic       pull_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       rbit_o,
  output logic       presence_o
);
  localparam int MAX_US = (RST_TOTAL_US > SLOT_US) ? RST_TOTAL_US : SLOT_US;
  localparam int US_W   = $clog2(MAX_US + 1);

  localparam logic [US_W-1:0] T_RST_LOW   = US_W'(RST_LOW_US);
  localparam logic [US_W-1:0] T_RST_TOTAL = US_W'(RST_TOTAL_US);
  localparam logic [US_W-1:0] T_PRES_AT   = US_W'(RST_LOW_US + PRES_WAIT_US);
  localparam logic [US_W-1:0] T_SLOT      = US_W'(SLOT_US);
  localparam logic [US_W-1:0] T_SHORT     = US_W'(SHORT_LOW_US);
  localparam logic [US_W-1:0] T_LONG      = US_W'(LONG_LOW_US);
  localparam logic [US_W-1:0] T_READ_AT   = US_W'(READ_AT_US);

  owire_op_e       op_q;
  logic            wbit_q;
  logic [US_W-1:0] us_q;
  logic [US_W-1:0] us_nx;
  logic            smp_q;

  logic [US_W-1:0] low_len;
  logic [US_W-1:0] sample_at;
  logic [US_W-1:0] total_len;

  assign accept = start_i && !busy_o && (owire_op_e'(op_i) != OP_NONE);
  assign us_nx  = us_q + 1'b1;

  // Per-operation thresholds
  always_comb begin
    case (op_q)
      OP_RESET: begin
        low_len   = T_RST_LOW;
        sample_at = T_PRES_AT;
        total_len = T_RST_TOTAL;
      end
      OP_WRITE: begin
        low_len   = wbit_q ? T_SHORT : T_LONG;
        sample_at = T_READ_AT;
        total_len = T_SLOT;
      end
      default: begin
        low_len   = T_SHORT;
        sample_at = T_READ_AT;
        total_len = T_SLOT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q       <= OP_NONE;
      wbit_q     <= 1'b1;
      us_q       <= '0;
      smp_q      <= 1'b1;
      pull_low_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      rbit_o     <= 1'b0;
      presence_o <= 1'b0;
    end else if (accept) begin
      op_q       <= owire_op_e'(op_i);
      wbit_q     <= wbit_i;
      us_q       <= '0;
      smp_q      <= 1'b1;
      pull_low_o <= 1'b1;
      busy_o     <= 1'b1;
      done_o     <= 1'b0;
    end else if (busy_o) begin
      done_o <= 1'b0;
      if (tick) begin
        us_q       <= us_nx;
        pull_low_o <= (us_nx < low_len);
        if (us_nx == sample_at) begin
          smp_q <= line_s;
        end
        if (us_nx == total_len) begin
          busy_o     <= 1'b0;
          done_o     <= 1'b1;
          pull_low_o <= 1'b0;
          if (op_q == OP_RESET) presence_o <= !smp_q;
          if (op_q == OP_READ)  rbit_o     <= smp_q;
        end
      end
    end else begin
      done_o     <= 1'b0;
      pull_low_o <= 1'b0;
    end
  end
endmodule

// File: rtl/owire_bitmaster.sv
module owire_bitmaster #(
  parameter int CLKS_PER_US  = 125,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_LOW_US   = 480,
  parameter int RST_TOTAL_US = 960,
  parameter int PRES_WAIT_US = 70,
  parameter int SLOT_US      = 61,
  parameter int SHORT_LOW_US = 6,
  parameter int LONG_LOW_US  = 60,
  parameter int READ_AT_US   = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       wbit_i,
  input  logic       line_i,
  output logic       pull_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       rbit_o,
  output logic       presence_o
);
  logic tick;
  logic accept;
  logic line_s;

  owire_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .tick    (tick)
  );

  owire_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .line_async (line_i),
    .line_sync  (line_s)
  );

  owire_slot_seq #(
    .RST_LOW_US   (RST_LOW_US),
    .RST_TOTAL_US (RST_TOTAL_US),
    .PRES_WAIT_US (PRES_WAIT_US),
    .SLOT_US      (SLOT_US),
    .SHORT_LOW_US (SHORT_LOW_US),
    .LONG_LOW_US  (LONG_LOW_US),
    .READ_AT_US   (READ_AT_US)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .start_i    (start_i),
    .op_i       (op_i),
    .wbit_i     (wbit_i),
    .line_s     (line_s),
    .accept     (accept),
    .pull_low_o (pull_low_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rbit_o     (rbit_o),
    .presence_o (presence_o)
  );
endmodule

// File: rtl/owire_bitmaster_chk.sv
module owire_bitmaster_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic [1:0] op_i,
  input logic       pull_low_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       rbit_o,
  input logic       presence_o
);
  assert_idle_no_pull_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !pull_low_o);

  assert_presence_at_done_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(presence_o) |-> done_o);

  assert_rbit_at_done_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(rbit_o) |-> done_o);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(start_i) && $past(op_i) != 2'b11));

  assert_noop_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && op_i == 2'b11) |=> !busy_o);
endmodule

bind owire_bitmaster owire_bitmaster_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .op_i       (op_i),
  .pull_low_o (pull_low_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rbit_o     (rbit_o),
  .presence_o (presence_o)
);

// File: tb/owire_bitmaster_test.sv
module owire_bitmaster_test;
  localparam int C = 4;  // clocks per microsecond in the bench

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [1:0] op_i = 2'b11;
  logic wbit_i = 1'b1;
  logic line_i;
  logic pull, busy, done, rbit, pres;

  int checks = 0;
  int fails  = 0;

  // device model: 0 silent, 1 answers reset with presence, 2 reads as zero
  int mode = 0;
  logic pull_prev = 1'b0;
  int since_fall = 1000000;
  int since_rise = 1000000;
  logic dev_low;

  always #4 clk = ~clk;  // 125 MHz

  owire_bitmaster #(.CLKS_PER_US(C)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .wbit_i(wbit_i),
    .line_i(line_i), .pull_low_o(pull), .busy_o(busy), .done_o(done),
    .rbit_o(rbit), .presence_o(pres)
  );

  always @(posedge clk) begin
    pull_prev <= pull;
    since_fall <= (pull_prev && !pull) ? 0 : since_fall + 1;
    since_rise <= (!pull_prev && pull) ? 0 : since_rise + 1;
  end

  assign dev_low = (mode == 1 && since_fall >= 15*C && since_fall < 200*C) ||
                   (mode == 2 && since_rise < 30*C);
  assign line_i = !(pull || dev_low);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issues one operation; optional second start injected at cycle inj_at.
  task automatic run_op(input logic [1:0] op, input logic wb, input int inj_at,
                        output int busy_n, output int low_n, output int done_n);
    busy_n = 0; low_n = 0; done_n = 0;
    @(negedge clk); op_i = op; wbit_i = wb; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (i == inj_at) begin op_i = 2'b00; start_i = 1'b1; end
      else start_i = 1'b0;
      if (busy) busy_n++;
      if (pull) low_n++;
      if (done) begin
        done_n++;
        @(negedge clk);
        if (done) done_n++;
        break;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  task automatic t_reset_state();
    check(!pull && !busy && !done, "R1 idle outputs", {pull, busy, done}, 0);
    check(!rbit && !pres, "R1 result outputs", {rbit, pres}, 0);
  endtask

  task automatic t_reset_absent();
    int b, l, d;
    mode = 0;
    run_op(2'b00, 1'b1, -1, b, l, d);
    check(pres == 1'b0, "R3 no presence", pres, 0);
  endtask

  task automatic t_reset_present();
    int b, l, d;
    mode = 1;
    run_op(2'b00, 1'b1, -1, b, l, d);
    check(l == 480*C, "R2 reset low length", l, 480*C);
    check(b == 960*C, "R2 reset total length", b, 960*C);
    check(d == 1, "R6 single done", d, 1);
    check(pres == 1'b1, "R3 presence seen", pres, 1);
    mode = 0;
  endtask

  task automatic t_write(input logic wb);
    int b, l, d;
    mode = 0;
    run_op(2'b01, wb, -1, b, l, d);
    check(l == (wb ? 6*C : 60*C), "R4 write low length", l, wb ? 6*C : 60*C);
    check(b == 61*C, "R4 write slot length", b, 61*C);
    check(d == 1, "R6 single done", d, 1);
  endtask

  task automatic t_read(input int dev_mode, input logic exp_bit);
    int b, l, d;
    mode = dev_mode;
    run_op(2'b10, 1'b1, -1, b, l, d);
    check(rbit == exp_bit, "R5 read bit", rbit, exp_bit);
    check(l == 6*C, "R5 read low length", l, 6*C);
    check(b == 61*C, "R5 read slot length", b, 61*C);
    check(pres == 1'b1, "R3 presence held over read", pres, 1);
    mode = 0;
  endtask

  task automatic t_busy_start();
    int b, l, d;
    run_op(2'b01, 1'b1, 20, b, l, d);
    check(b == 61*C && l == 6*C, "R7 start while busy ignored", b, 61*C);
    check(d == 1, "R7 single done", d, 1);
    repeat (3) @(negedge clk);
    check(!busy, "R7 no queued op", busy, 0);
  endtask

  task automatic t_noop();
    int seen = 0;
    @(negedge clk); op_i = 2'b11; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (busy || pull || done) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R7 op 11 ignored", seen, 0);
    check(pres == 1'b1 && rbit == 1'b0, "R7 results untouched", {pres, rbit}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired: actual busy=%0d expected completion", busy);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_reset_absent();
    t_reset_present();
    t_write(1'b1);
    t_write(1'b0);
    t_read(0, 1'b1);
    t_read(2, 1'b0);
    t_busy_start();
    t_noop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule